// File: doc/BRIEF.md
# PCM Voice Codec Serial Port

This block is the digital side of a single-channel telephone voice codec. On the transmit side it takes a 14-bit two's-complement linear sample from a converter model and compresses it into an 8-bit G.711 code word. A run-time select input chooses A-law or mu-law. The code word is shifted out serially, most significant bit first. Each word is framed by a short transmit sync pulse. The output pin is modelled as a data bit plus a drive enable, so that the pad can be open-drain and released outside its slot.

On the receive side the block captures a serial 8-bit code word, framed by its own short sync pulse, and expands it back to a 14-bit linear sample. It pulses a strobe whenever that sample is updated. The two directions share one bit clock but are framed independently.

A power-down input stops both directions. All logic runs on one system clock. The bit clock and the sync pulses are sampled by that clock, and their rising and falling transitions are detected inside the block.

Top module: `pcm_voice_port`

## Requirements
- R1: When `txSync` is high at a detected falling edge of `bitClk`, the next 8 rising edges each present one code bit on `txData`, bit 7 first, with `txDrive` high. The 9th rising edge sets `txDrive` low, and it stays low until the next framed word.
- R2: With `lawSel`=0 (mu-law), the code is built as follows. Take the magnitude of the sample, clip it to 8158 and add 33. The segment s (0..7) is the position of the highest set bit minus 5. The step is bits [s+4:s+1]. The code is {0,s,step} XOR 8'hFF for samples of zero or above, and XOR 8'h7F for negative samples. A zero sample therefore gives 8'hFF.
- R3: With `lawSel`=1 (A-law), the sample is first shifted right arithmetically by one to give v. The magnitude m is v for v≥0 and −v−1 for v<0. Segment 0 holds m<32, with step m/2. Otherwise the segment s is the position of the highest set bit minus 4, and the step is bits [s+3:s]. The code is {0,s,step} XOR 8'hD5 for v≥0 and XOR 8'h55 for v<0, so the even bits are inverted. A zero sample gives 8'hD5.
- R4: When `rxSync` is high at a detected falling edge of `bitClk`, `pcmIn` is sampled at each of the next 8 falling edges, bit 7 first. After the 8th bit, `rxSample` is updated and `rxValid` is high for exactly one clock. `rxSample` does not change at any other time.
- R5: Mu-law expansion works on x = code XOR 8'hFF, with s = x[6:4] and t = x[3:0]. The magnitude is ((2t+33)<<s)−33. The sample is negative when x[7]=1.
- R6: A-law expansion works on x = code XOR 8'h55, with s = x[6:4] and t = x[3:0]. The magnitude is 2t+1 when s=0 and (2t+33)<<(s−1) otherwise. The result is doubled to 14 bits, and it is positive when x[7]=1.
- R7: A sync that arrives before a word is complete restarts that direction. On transmit, the next rising edge reloads from the current sample. On receive, the partial word is discarded and produces no `rxValid`.
- R8: The transmit and receive syncs may occur at different bit positions, and each direction frames correctly on its own.
- R9: While `pwrOn`=0, `txDrive` is low, `rxValid` stays low and `rxSample` holds its value. Any word in progress is abandoned, so a fresh sync is needed after `pwrOn` returns to 1.
- R10: After reset, `txDrive`=0, `rxValid`=0 and `rxSample`=0. With no sync, running `bitClk` never raises `txDrive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bitClk | input | 1 | Serial bit clock, sampled by `clk` |
| txSync | input | 1 | Transmit short frame sync |
| rxSync | input | 1 | Receive short frame sync |
| lawSel | input | 1 | 1 = A-law, 0 = mu-law |
| pwrOn | input | 1 | 1 = operating, 0 = power-down |
| txSample | input | 14 | Linear sample to transmit, two's complement |
| pcmIn | input | 1 | Serial receive data |
| txData | output | 1 | Serial transmit data bit |
| txDrive | output | 1 | Pad drive enable, high only in the 8 transmit slots |
| rxSample | output | 14 | Expanded received sample, two's complement |
| rxValid | output | 1 | One-clock strobe when `rxSample` updates |

## Verification
The assertions take for granted several things about the inputs. `bitClk`, both syncs and `pcmIn` must be synchronous to `clk`, and each `bitClk` level must last at least one `clk` cycle, so that no rising and falling edge can be detected together. `txSample` and `lawSel` must be stable between a sync and the end of its word. The stimulus changes `bitClk`, the syncs and `pcmIn` together on a falling `clk` edge, holds each `bitClk` level for two `clk` cycles, and changes the sample and law only between frames. The one exception is the restart case, where the sample changes only after the restarting sync has been sampled.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int LIN_W   = 14;
  localparam int CODE_W  = 8;
  localparam int SEG_W   = 3;
  localparam int STEP_W  = 4;
  localparam int MU_BIAS = 33;
  localparam int MU_CLIP = 8158;
  localparam int CNT_W   = $clog2(CODE_W);

  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic rxShift;
    logic rxDone;
  } strobe_t;
endpackage

// File: rtl/pcm_compress.sv
module pcm_compress
  import pcm_port_pkg::*;
(
  input  logic [LIN_W-1:0]  linIn,
  input  logic              aLaw,
  output logic [CODE_W-1:0] codeOut
);
  logic              muNeg;
  logic [LIN_W:0]    muMagW;
  logic [LIN_W-2:0]  muClip;
  logic [LIN_W-2:0]  muBiased;
  logic [SEG_W-1:0]  muSeg;
  logic [STEP_W-1:0] muStep;
  logic [CODE_W-1:0] muCode;

  logic [LIN_W-2:0]  aVal;
  logic              aNeg;
  logic [LIN_W-3:0]  aMag;
  logic [SEG_W-1:0]  aSeg;
  logic [STEP_W-1:0] aStep;
  logic [CODE_W-1:0] aCode;

  // mu-law: biased magnitude, highest-bit segment search
  always_comb begin
    muNeg  = linIn[LIN_W-1];
    muMagW = muNeg ? (~{linIn[LIN_W-1], linIn} + (LIN_W+1)'(1))
                   : {1'b0, linIn};
    muClip = (muMagW > (LIN_W+1)'(MU_CLIP)) ? (LIN_W-1)'(MU_CLIP)
                                            : muMagW[LIN_W-2:0];
    muBiased = muClip + (LIN_W-1)'(MU_BIAS);
    muSeg = '0;
    for (int i = 0; i < 8; i++) begin
      if (muBiased[i+5]) muSeg = SEG_W'(i);
    end
    muStep = STEP_W'(muBiased >> ({1'b0, muSeg} + 4'd1));
    muCode = {1'b0, muSeg, muStep} ^ (muNeg ? 8'h7F : 8'hFF);
  end

  // A-law: 13-bit value, one's complement magnitude for negatives
  always_comb begin
    aVal = linIn[LIN_W-1:1];
    aNeg = aVal[LIN_W-2];
    aMag = aNeg ? ~aVal[LIN_W-3:0] : aVal[LIN_W-3:0];
    aSeg = '0;
    for (int i = 0; i < 7; i++) begin
      if (aMag[i+5]) aSeg = SEG_W'(i + 1);
    end
    aStep = (aSeg == '0) ? aMag[4:1] : STEP_W'(aMag >> aSeg);
    aCode = {1'b0, aSeg, aStep} ^ (aNeg ? 8'h55 : 8'hD5);
  end

  assign codeOut = aLaw ? aCode : muCode;
endmodule

// File: rtl/pcm_expand.sv
module pcm_expand
  import pcm_port_pkg::*;
(
  input  logic [CODE_W-1:0] codeIn,
  input  logic              aLaw,
  output logic [LIN_W-1:0]  linOut
);
  logic [CODE_W-1:0] muX;
  logic [LIN_W-1:0]  muT;
  logic [LIN_W-1:0]  muMag;
  logic [LIN_W-1:0]  muLin;

  logic [CODE_W-1:0] aX;
  logic [LIN_W-2:0]  aBase;
  logic [LIN_W-2:0]  aMag;
  logic [LIN_W-2:0]  aVal;
  logic [LIN_W-1:0]  aLin;

  always_comb begin
    muX   = ~codeIn;
    muT   = ({9'd0, muX[3:0], 1'b0} + LIN_W'(MU_BIAS)) << muX[6:4];
    muMag = muT - LIN_W'(MU_BIAS);
    muLin = muX[7] ? (~muMag + LIN_W'(1)) : muMag;
  end

  always_comb begin
    aX    = codeIn ^ 8'h55;
    aBase = {8'd0, aX[3:0], 1'b1};
    aMag  = (aX[6:4] == 3'd0) ? aBase
                              : ((aBase + (LIN_W-1)'(32)) << (aX[6:4] - 3'd1));
    aVal  = aX[7] ? aMag : (~aMag + (LIN_W-1)'(1));
    aLin  = {aVal, 1'b0};
  end

  assign linOut = aLaw ? aLin : muLin;
endmodule

// File: rtl/pcm_port_ctrl.sv
module pcm_port_ctrl
  import pcm_port_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    bitClk,
  input  logic    txSync,
  input  logic    rxSync,
  input  logic    pwrOn,
  output strobe_t strb,
  output logic    txDrive
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CODE_W - 1);

  logic             bckQ;
  logic             riseEv;
  logic             fallEv;
  logic             txArmed;
  logic             txActive;
  logic [CNT_W-1:0] txCnt;
  logic             rxActive;
  logic [CNT_W-1:0] rxCnt;

  assign riseEv = bitClk & ~bckQ;
  assign fallEv = ~bitClk & bckQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bckQ     <= 1'b0;
      txArmed  <= 1'b0;
      txActive <= 1'b0;
      txCnt    <= '0;
      rxActive <= 1'b0;
      rxCnt    <= '0;
    end else begin
      bckQ <= bitClk;
      if (!pwrOn) begin
        txArmed  <= 1'b0;
        txActive <= 1'b0;
        txCnt    <= '0;
        rxActive <= 1'b0;
        rxCnt    <= '0;
      end else begin
        if (fallEv && txSync) txArmed <= 1'b1;
        if (riseEv) begin
          if (txArmed) begin
            txArmed  <= 1'b0;
            txActive <= 1'b1;
            txCnt    <= '0;
          end else if (txActive) begin
            if (txCnt == LAST_BIT) txActive <= 1'b0;
            else                   txCnt    <= txCnt + 1'b1;
          end
        end
        if (fallEv) begin
          if (rxSync) begin
            rxActive <= 1'b1;
            rxCnt    <= '0;
          end else if (rxActive) begin
            if (rxCnt == LAST_BIT) rxActive <= 1'b0;
            else                   rxCnt    <= rxCnt + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    strb.txLoad  = pwrOn & riseEv & txArmed;
    strb.txShift = pwrOn & riseEv & ~txArmed & txActive & (txCnt != LAST_BIT);
    strb.rxShift = pwrOn & fallEv & ~rxSync & rxActive;
    strb.rxDone  = pwrOn & fallEv & ~rxSync & rxActive & (rxCnt == LAST_BIT);
  end

  assign txDrive = txActive;

  // R9: power-down releases the pad on the next clock
  p_pd_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrOn |=> !txDrive);
  // R1: a load starts the drive slot
  p_load_drives_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strb.txLoad |=> txDrive);
  // R1: the edge after the last bit releases the pad unless re-armed
  p_slot_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (riseEv && txActive && !txArmed && txCnt == LAST_BIT) |=> !txDrive);
  // R7: a receive sync always restarts the word from bit 0
  p_rx_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrOn && fallEv && rxSync) |=> (rxActive && rxCnt == '0));
endmodule

// File: rtl/pcm_port_datapath.sv
module pcm_port_datapath
  import pcm_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strb,
  input  logic [LIN_W-1:0] txSample,
  input  logic             lawSel,
  input  logic             pcmIn,
  output logic             txData,
  output logic [LIN_W-1:0] rxSample,
  output logic             rxValid
);
  logic [CODE_W-1:0] txCode;
  logic [CODE_W-1:0] txShiftReg;
  logic [CODE_W-1:0] rxShiftReg;
  logic [CODE_W-1:0] rxWord;
  logic [LIN_W-1:0]  rxLin;

  pcm_compress u_compress (
    .linIn   (txSample),
    .aLaw    (lawSel),
    .codeOut (txCode)
  );

  assign rxWord = {rxShiftReg[CODE_W-2:0], pcmIn};

  pcm_expand u_expand (
    .codeIn (rxWord),
    .aLaw   (lawSel),
    .linOut (rxLin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txShiftReg <= '0;
      rxShiftReg <= '0;
      rxSample   <= '0;
      rxValid    <= 1'b0;
    end else begin
      if (strb.txLoad)       txShiftReg <= txCode;
      else if (strb.txShift) txShiftReg <= {txShiftReg[CODE_W-2:0], 1'b0};
      if (strb.rxShift)      rxShiftReg <= rxWord;
      if (strb.rxDone)       rxSample   <= rxLin;
      rxValid <= strb.rxDone;
    end
  end

  assign txData = txShiftReg[CODE_W-1];

  // R4: the update strobe is a single-clock pulse
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |=> !rxValid);
  // R4: the sample moves only together with the strobe
  p_sample_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rxValid |-> $stable(rxSample));
  // R2: a zero sample compresses to all ones under mu-law
  p_mu_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.txLoad && !lawSel && txSample == '0) |=> txShiftReg == 8'hFF);
  // R3: a zero sample compresses to the even-inverted positive zero under A-law
  p_a_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.txLoad && lawSel && txSample == '0) |=> txShiftReg == 8'hD5);
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
  import pcm_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bitClk,
  input  logic             txSync,
  input  logic             rxSync,
  input  logic             lawSel,
  input  logic             pwrOn,
  input  logic [LIN_W-1:0] txSample,
  input  logic             pcmIn,
  output logic             txData,
  output logic             txDrive,
  output logic [LIN_W-1:0] rxSample,
  output logic             rxValid
);
  strobe_t strb;

  pcm_port_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .bitClk  (bitClk),
    .txSync  (txSync),
    .rxSync  (rxSync),
    .pwrOn   (pwrOn),
    .strb    (strb),
    .txDrive (txDrive)
  );

  pcm_port_datapath u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .txSample (txSample),
    .lawSel   (lawSel),
    .pcmIn    (pcmIn),
    .txData   (txData),
    .rxSample (rxSample),
    .rxValid  (rxValid)
  );

  // R9: no sample update while powered down
  p_pd_no_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrOn |=> !rxValid);
endmodule

// File: tb/pcm_voice_port_tb.sv
module pcm_voice_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bitClk = 1'b0;
  logic        txSync = 1'b0;
  logic        rxSync = 1'b0;
  logic        lawSel = 1'b0;
  logic        pwrOn = 1'b1;
  logic [13:0] txSample = '0;
  logic        pcmIn = 1'b0;
  logic        txData;
  logic        txDrive;
  logic [13:0] rxSample;
  logic        rxValid;

  int checks = 0;
  int fails = 0;
  int rxPulses = 0;
  logic signed [13:0] rxLast = '0;
  bit done = 1'b0;

  pcm_voice_port u_dut (
    .clk(clk), .rst_n(rst_n), .bitClk(bitClk), .txSync(txSync),
    .rxSync(rxSync), .lawSel(lawSel), .pwrOn(pwrOn), .txSample(txSample),
    .pcmIn(pcmIn), .txData(txData), .txDrive(txDrive),
    .rxSample(rxSample), .rxValid(rxValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rxValid) begin
      rxPulses++;
      rxLast = rxSample;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int encMu(input int s);
    int mag, seg, step;
    bit neg;
    neg = (s < 0);
    mag = neg ? -s : s;
    if (mag > 8158) mag = 8158;
    mag += 33;
    seg = 0;
    while (seg < 7 && mag >= (64 << seg)) seg++;
    step = (mag >> (seg + 1)) - 16;
    return neg ? 127 - (seg*16 + step) : 255 - (seg*16 + step);
  endfunction

  function automatic int encA(input int s);
    int v, mag, seg, step;
    bit pos;
    v = s >>> 1;
    pos = (v >= 0);
    mag = pos ? v : -v - 1;
    if (mag < 32) begin
      seg = 0; step = mag / 2;
    end else begin
      seg = 1;
      while (seg < 7 && mag >= (32 << seg)) seg++;
      step = (mag >> seg) - 16;
    end
    return (seg*16 + step) ^ (pos ? 'hD5 : 'h55);
  endfunction

  function automatic int decMu(input int c);
    int x, seg, step, mag;
    x = c ^ 255;
    seg = (x >> 4) & 7; step = x & 15;
    mag = ((2*step + 33) << seg) - 33;
    return (x >= 128) ? -mag : mag;
  endfunction

  function automatic int decA(input int c);
    int x, seg, step, mag;
    x = c ^ 'h55;
    seg = (x >> 4) & 7; step = x & 15;
    mag = (seg == 0) ? 2*step + 1 : (2*step + 33) << (seg - 1);
    return ((x >= 128) ? mag : -mag) * 2;
  endfunction

  task automatic bitStep(input logic ts, input logic rs, input logic din,
                         output logic dq, output logic oe);
    bitClk = 1'b1; txSync = ts; rxSync = rs; pcmIn = din;
    repeat (HALF_BIT) @(negedge clk);
    dq = txData; oe = txDrive;
    bitClk = 1'b0;
    repeat (HALF_BIT) @(negedge clk);
  endtask

  // one tx word at step 0, one rx word framed at step d
  task automatic runFrame(input int s, input int code, input int d, input bit law);
    logic dq, oe;
    logic [7:0] got;
    logic [7:0] cb;
    int driveErr, p0, expCode, expLin;
    string tTag, rTag;
    lawSel = law; txSample = 14'(s); cb = 8'(code);
    p0 = rxPulses; driveErr = 0; got = '0;
    for (int i = 0; i < d + 10; i++) begin
      bitStep(i == 0, i == d, (i > d && i <= d + 8) ? cb[d + 8 - i] : 1'b0, dq, oe);
      if (i >= 1 && i <= 8) begin
        got[8 - i] = dq;
        if (!oe) driveErr++;
      end else if (i == 0 || i == 9) begin
        if (oe) driveErr++;
      end
    end
    expCode = law ? encA(s) : encMu(s);
    expLin  = law ? decA(code) : decMu(code);
    tTag = law ? "R3 A-law code" : "R2 mu-law code";
    rTag = law ? "R6 A-law sample" : "R5 mu-law sample";
    if (d != 0) begin
      tTag = {tTag, " R8"};
      rTag = {rTag, " R8"};
    end
    check(int'(got) == expCode, tTag, int'(got), expCode);
    check(driveErr == 0, "R1 drive slot errors", driveErr, 0);
    check(rxPulses == p0 + 1, "R4 strobe count", rxPulses - p0, 1);
    check(int'(rxLast) == expLin, rTag, int'(rxLast), expLin);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic dq, oe;
    int cnt, p0;
    logic [13:0] held;
    int bnd [15] = '{-8192, -8159, -8158, -33, -1, 0, 1, 2, 31, 32,
                     4095, -4096, 8157, 8158, 8191};

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(txDrive == 1'b0, "R10 txDrive after reset", int'(txDrive), 0);
    check(rxValid == 1'b0, "R10 rxValid after reset", int'(rxValid), 0);
    check(rxSample == '0, "R10 rxSample after reset", int'(rxSample), 0);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      bitStep(1'b0, 1'b0, 1'b1, dq, oe);
      if (oe) cnt++;
    end
    check(cnt == 0, "R10 no drive without sync", cnt, 0);
    check(rxPulses == 0, "R10 no strobe without sync", rxPulses, 0);

    // boundary samples, both laws
    for (int law = 0; law < 2; law++)
      for (int k = 0; k < 15; k++)
        runFrame(bnd[k], (k * 37 + 5) & 255, k % 4, law[0]);

    // sweep: every code received, samples spread across the range
    for (int law = 0; law < 2; law++)
      for (int f = 0; f < 256; f++)
        runFrame(-8192 + f*64 + (f*7) % 64, f, f % 3, law[0]);

    // R7 transmit restart mid-word
    lawSel = 1'b0; txSample = 14'(1000);
    bitStep(1'b1, 1'b0, 1'b0, dq, oe);
    bitStep(1'b0, 1'b0, 1'b0, dq, oe);
    bitStep(1'b0, 1'b0, 1'b0, dq, oe);
    bitStep(1'b1, 1'b0, 1'b0, dq, oe);
    txSample = 14'(-2500);
    begin
      logic [7:0] got;
      got = '0; cnt = 0;
      for (int i = 0; i < 8; i++) begin
        bitStep(1'b0, 1'b0, 1'b0, dq, oe);
        got[7 - i] = dq;
        if (!oe) cnt++;
      end
      bitStep(1'b0, 1'b0, 1'b0, dq, oe);
      if (oe) cnt++;
      check(int'(got) == encMu(-2500), "R7 tx restart code", int'(got), encMu(-2500));
      check(cnt == 0, "R7 tx restart drive errors", cnt, 0);
    end

    // R7 receive restart discards partial word
    lawSel = 1'b1; p0 = rxPulses;
    bitStep(1'b0, 1'b1, 1'b0, dq, oe);
    for (int i = 0; i < 3; i++) bitStep(1'b0, 1'b0, 1'b1, dq, oe);
    bitStep(1'b0, 1'b1, 1'b0, dq, oe);
    begin
      logic [7:0] cb;
      cb = 8'h3C;
      for (int i = 0; i < 8; i++) bitStep(1'b0, 1'b0, cb[7 - i], dq, oe);
      bitStep(1'b0, 1'b0, 1'b0, dq, oe);
      bitStep(1'b0, 1'b0, 1'b0, dq, oe);
      check(rxPulses == p0 + 1, "R7 rx restart strobe count", rxPulses - p0, 1);
      check(int'(rxLast) == decA('h3C), "R7 rx restart sample", int'(rxLast), decA('h3C));
    end

    // R9 power-down for a whole frame
    held = rxSample; p0 = rxPulses; pwrOn = 1'b0; cnt = 0;
    for (int i = 0; i < 12; i++) begin
      bitStep(i == 0, i == 0, 1'b1, dq, oe);
      if (oe) cnt++;
    end
    check(cnt == 0, "R9 drive while powered down", cnt, 0);
    check(rxPulses == p0, "R9 strobe while powered down", rxPulses - p0, 0);
    check(rxSample == held, "R9 sample held", int'(rxSample), int'(held));

    // R9 power-down mid-word abandons both words
    pwrOn = 1'b1; p0 = rxPulses;
    bitStep(1'b1, 1'b1, 1'b0, dq, oe);
    bitStep(1'b0, 1'b0, 1'b1, dq, oe);
    bitStep(1'b0, 1'b0, 1'b1, dq, oe);
    pwrOn = 1'b0;
    bitStep(1'b0, 1'b0, 1'b1, dq, oe);
    pwrOn = 1'b1; cnt = 0;
    for (int i = 0; i < 10; i++) begin
      bitStep(1'b0, 1'b0, 1'b1, dq, oe);
      if (oe) cnt++;
    end
    check(cnt == 0, "R9 no drive after resume without sync", cnt, 0);
    check(rxPulses == p0, "R9 no strobe after resume without sync", rxPulses - p0, 0);

    // R9 normal operation after resume
    runFrame(-1234, 'hA7, 2, 1'b0);
    runFrame(777, 'h12, 0, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule